// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from one clock domain to a second, unrelated clock domain. A producer on the write clock presents a word and raises its enable. The word is stored when the FIFO is not full. A consumer on the read clock raises its enable. The oldest stored word is then registered onto the read data output when the FIFO is not empty. Each side has its own active-low asynchronous reset.

Each side keeps its pointer in binary to address the register array. It also keeps the pointer in registered Gray code, and only the Gray value is passed to the other side, through a two-flop synchronizer. Each side computes its flag from its own next pointer and the synchronized pointer of the other side, and registers the result. Because of this the flags are conservative. Full can stay high for a few write-clock cycles after a read has freed space. Empty can stay high for a few read-clock cycles after a write has added data. Neither flag ever reports space or data that does not exist.

Top module: `dcf_fifo`

## Requirements
- R1: While either reset is low, and after both resets are released with no traffic, `empty_o` is 1, `full_o` is 0 and `rdata_o` is 0.
- R2: A word on `wdata_i` is stored at a rising edge of `wclk_i` when `wen_i` is 1 and `full_o` is 0. Every stored word is delivered exactly once, in the order it was written.
- R3: A read is accepted at a rising edge of `rclk_i` when `ren_i` is 1 and `empty_o` is 0. At that edge, `rdata_o` takes the oldest unread word.
- R4: With no reads in progress, `full_o` rises at the write edge that stores the DEPTH-th unread word (DEPTH = 2^ADDR_W). It stays 0 before that edge.
- R5: A write attempted while `full_o` is 1 is ignored. No stored word is overwritten, and the write pointer does not move.
- R6: A read attempted while `empty_o` is 1 is ignored. `rdata_o` holds its value and the read pointer does not move. More generally, `rdata_o` changes only at an accepted read.
- R7: The Gray pointer that each side sends across changes in at most one bit per edge of its own clock.
- R8: After a write into an empty FIFO, `empty_o` falls no earlier than the second and no later than the fourth rising `rclk_i` edge. `empty_o` rises at the read edge that takes the last stored word.
- R9: After a read from a full FIFO, `full_o` stays 1 for at least one more write edge and falls within four write edges. At no time does `full_o`=0 coincide with DEPTH unread words, or `empty_o`=0 with zero unread words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-side clock |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low |
| wen_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Word to store |
| full_o | output | 1 | No free slot (conservative) |
| rclk_i | input | 1 | Read-side clock |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low |
| ren_i | input | 1 | Read request |
| rdata_o | output | DATA_W | Word taken by the most recent accepted read |
| empty_o | output | 1 | No unread word (conservative) |

## Verification
The bench fills the FIFO to the brim with reads held off. It then keeps pushing. A design that compared the raw pointers instead of the MSB-inverted Gray value would never raise full, or would overwrite the oldest word, and the drain would then show a foreign word. The bench reads an empty FIFO and follows with a single write and read. A read pointer that slipped past the write pointer would return stale memory instead of the new word. Flag latency is timed in both directions: a missing synchronizer stage makes empty fall too early, and a flag computed from the current rather than the next pointer makes full rise one write too late. Random traffic on unrelated clock periods is scored against a queue model, which catches reordering, duplication and loss.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned PTR_MAX_W  = 32;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef logic [PTR_MAX_W-1:0] wide_ptr_t;

  function automatic wide_ptr_t bin2gray(input wide_ptr_t b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = dcf_pkg::SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ptr.sv
`timescale 1ns/1ps
// One side's pointer: binary for addressing, registered Gray for crossing,
// registered flag from the next pointer. FULL_SIDE selects the full compare.
module dcf_ptr #(
  parameter int unsigned ADDR_W    = 3,
  parameter bit          FULL_SIDE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W:0]   peer_gray_i,
  output logic              adv_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W:0]   bin_o,
  output logic [ADDR_W:0]   gray_o,
  output logic              flag_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  // full: peer equals ours with the two top bits flipped
  localparam logic [PTR_W-1:0] INV_MASK =
    FULL_SIDE ? (PTR_W'(3) << (PTR_W - 2)) : '0;
  localparam logic FLAG_RST = ~FULL_SIDE;

  logic [PTR_W-1:0] bin_q, gray_q, bin_nx, gray_nx;
  logic             flag_q, flag_nx, adv;

  assign adv     = req_i & ~flag_q;
  assign bin_nx  = bin_q + PTR_W'(adv);
  assign gray_nx = PTR_W'(dcf_pkg::bin2gray(dcf_pkg::wide_ptr_t'(bin_nx)));
  assign flag_nx = (gray_nx == (peer_gray_i ^ INV_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
      flag_q <= FLAG_RST;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= gray_nx;
      flag_q <= flag_nx;
    end
  end

  assign adv_o  = adv;
  assign addr_o = bin_q[ADDR_W-1:0];
  assign bin_o  = bin_q;
  assign gray_o = gray_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni)  rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              ren_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0]  wbin, rbin, wgray, rgray, wq2, rq2;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wadv, radv;

  dcf_ptr #(.ADDR_W(ADDR_W), .FULL_SIDE(1'b1)) u_wptr (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .req_i(wen_i), .peer_gray_i(rq2),
    .adv_o(wadv), .addr_o(waddr), .bin_o(wbin), .gray_o(wgray), .flag_o(full_o)
  );

  dcf_ptr #(.ADDR_W(ADDR_W), .FULL_SIDE(1'b0)) u_rptr (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .req_i(ren_i), .peer_gray_i(wq2),
    .adv_o(radv), .addr_o(raddr), .bin_o(rbin), .gray_o(rgray), .flag_o(empty_o)
  );

  dcf_sync #(.WIDTH(PTR_W)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(wgray), .q_o(wq2)
  );

  dcf_sync #(.WIDTH(PTR_W)) u_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rgray), .q_o(rq2)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i(wclk_i), .we_i(wadv), .waddr_i(waddr), .wdata_i(wdata_i),
    .rclk_i(rclk_i), .rrst_ni(rrst_ni), .re_i(radv), .raddr_i(raddr),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 4
) (
  input logic              wclk_i,
  input logic              wrst_ni,
  input logic              rclk_i,
  input logic              rrst_ni,
  input logic              full_o,
  input logic              empty_o,
  input logic              ren_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [PTR_W-1:0]  wbin,
  input logic [PTR_W-1:0]  rbin,
  input logic [PTR_W-1:0]  wgray,
  input logic [PTR_W-1:0]  rgray
);
  // R5
  no_write_when_full_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_o |=> $stable(wbin));

  // R6
  no_read_when_empty_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    empty_o |=> $stable(rbin));

  // R6
  rdata_hold_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !(ren_i && !empty_o) |=> $stable(rdata_o));

  // R7
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R7
  rgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dcf_fifo dcf_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) chk_i (
  .wclk_i(wclk_i), .wrst_ni(wrst_ni), .rclk_i(rclk_i), .rrst_ni(rrst_ni),
  .full_o(full_o), .empty_o(empty_o), .ren_i(ren_i), .rdata_o(rdata_o),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/dcf_fifo_tb_top.sv
`timescale 1ns/1ps
module dcf_fifo_tb_top;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  // traffic phases: write %, read %, write cycles
  localparam int PH_N = 4;
  localparam int PHASES [PH_N][3] = '{
    '{90, 20, 300}, '{20, 90, 300}, '{50, 50, 400}, '{100, 100, 300}
  };

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n, rrst_n, wen, ren, full, empty;
  logic [DATA_W-1:0] wdata, rdata;

  int n_tests = 0, n_fail = 0;
  bit wr_done = 1'b0, finished = 1'b0;
  logic [DATA_W-1:0] model_q [$];

  always #5    wclk = ~wclk;
  always #7.3  rclk = ~rclk;

  dcf_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wen_i(wen), .wdata_i(wdata), .full_o(full),
    .rclk_i(rclk), .rrst_ni(rrst_n), .ren_i(ren), .rdata_o(rdata), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [DATA_W-1:0] d);
    @(negedge wclk); wen = 1'b1; wdata = d;
    @(negedge wclk); wen = 1'b0;
  endtask

  task automatic pop_word(output logic [DATA_W-1:0] d);
    int t = 0;
    @(negedge rclk);
    while (empty && t < 50) begin @(negedge rclk); t++; end
    ren = 1'b1;
    @(negedge rclk); ren = 1'b0; d = rdata;
  endtask

  task automatic writer(input int pct, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      if (!full) chk(model_q.size() < DEPTH, "R9 full low with no space", model_q.size(), DEPTH - 1);
      wen   = (($urandom % 100) < pct);
      wdata = DATA_W'($urandom);
      if (wen && !full) model_q.push_back(wdata);
    end
    @(negedge wclk); wen = 1'b0;
    wr_done = 1'b1;
  endtask

  task automatic reader(input int pct);
    logic [DATA_W-1:0] exp_d, last;
    bit pend = 1'b0;
    int idle = 0;
    last = rdata;
    while (!(wr_done && idle > 40)) begin
      @(negedge rclk);
      if (pend) chk(rdata == exp_d, "R3 order", rdata, exp_d);
      else      chk(rdata == last, "R6 rdata hold", rdata, last);
      last = rdata; pend = 1'b0;
      if (!empty) chk(model_q.size() > 0, "R9 empty low with no data", model_q.size(), 1);
      ren = (($urandom % 100) < pct);
      if (ren && !empty && model_q.size() > 0) begin
        exp_d = model_q.pop_front(); pend = 1'b1;
      end
      if (wr_done) idle++;
    end
    @(negedge rclk); ren = 1'b0;
    if (pend) chk(rdata == exp_d, "R3 order", rdata, exp_d);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d, last;
    int cnt;
    wrst_n = 1'b0; rrst_n = 1'b0; wen = 1'b0; ren = 1'b0; wdata = '0;
    #40;
    // R1 during reset
    chk(empty == 1'b1, "R1 empty in reset", empty, 1);
    chk(full == 1'b0, "R1 full in reset", full, 0);
    chk(rdata == '0, "R1 rdata in reset", rdata, 0);
    @(negedge wclk); wrst_n = 1'b1;
    @(negedge rclk); rrst_n = 1'b1;
    repeat (6) @(negedge rclk);
    chk(empty == 1'b1 && full == 1'b0, "R1 idle after reset", {empty, full}, 2);

    // R8 empty latency
    @(negedge wclk); wen = 1'b1; wdata = 8'hA5;
    @(posedge wclk); #1 wen = 1'b0;
    cnt = 0;
    while (empty && cnt < 10) begin @(posedge rclk); #1; cnt++; end
    chk(cnt >= 2 && cnt <= 4, "R8 empty fall latency", cnt, 3);
    pop_word(d);
    chk(d == 8'hA5, "R3 single word", d, 8'hA5);
    chk(empty == 1'b1, "R8 empty at last read", empty, 1);

    // R4 fill
    repeat (4) @(negedge wclk);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wclk);
      chk(full == 1'b0, "R4 full early", full, 0);
      wen = 1'b1; wdata = DATA_W'(8'h10 + i);
    end
    @(negedge wclk); wen = 1'b0;
    chk(full == 1'b1, "R4 full at DEPTH words", full, 1);

    // R5 writes while full
    @(negedge wclk); wen = 1'b1; wdata = 8'hEE;
    repeat (3) @(negedge wclk);
    wen = 1'b0;
    chk(full == 1'b1, "R5 full held", full, 1);

    // R9 full release latency
    @(negedge rclk); ren = 1'b1;
    @(posedge rclk); #1 ren = 1'b0;
    chk(rdata == 8'h10, "R5 oldest kept", rdata, 8'h10);
    @(posedge wclk); #1;
    chk(full == 1'b1, "R9 full held after read", full, 1);
    cnt = 1;
    while (full && cnt < 10) begin @(posedge wclk); #1; cnt++; end
    chk(cnt <= 4 && !full, "R9 full fall latency", cnt, 3);
    for (int i = 1; i < DEPTH; i++) begin
      pop_word(d);
      chk(d == DATA_W'(8'h10 + i), "R5 R2 drain order", d, 8'h10 + i);
    end
    @(negedge rclk);
    chk(empty == 1'b1, "R5 nothing extra stored", empty, 1);

    // R6 read while empty
    last = rdata;
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
    chk(rdata == last, "R6 rdata after empty read", rdata, last);
    push_word(8'h5A);
    pop_word(d);
    chk(d == 8'h5A, "R6 pointer unmoved", d, 8'h5A);
    repeat (6) @(negedge rclk);

    // random phases
    for (int p = 0; p < PH_N; p++) begin
      wr_done = 1'b0;
      fork
        writer(PHASES[p][0], PHASES[p][2]);
        reader(PHASES[p][1]);
      join
    end
    wr_done = 1'b1;
    reader(100);
    chk(model_q.size() == 0, "R2 all words delivered", model_q.size(), 0);
    chk(empty == 1'b1, "R2 empty at end", empty, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule